// File: doc/BRIEF.md
# Interleaved Flash Command Encoder

This block prepares flash commands for a bank of identical parallel flash devices that share one data bus. Given a command byte and a command offset expressed in device units, it produces the byte address to drive on the bus and the full-width data word that presents that command to every device in the bank at once. The geometry is supplied per request: how many bytes the bus carries, how many devices sit side by side on it (the interleave), and how many bytes each device's native type spans. A byte-order select picks whether the command byte lands in the lowest or the highest byte of each device lane.

A second path works in the other direction. It takes a raw status word read back from the bus and folds the per-device copies into one status value, in the byte order of a single device. Geometries the block cannot represent raise an error flag and silence all outputs. A build-time option places a register after both paths, with a valid flag that follows the input strobe by one cycle.

Top module: `flash_cmd_encoder`

## Requirements
- R1: With no unlock adjustment, `bus_addr` equals `cmd_ofs` times `dev_type` times `interleave`.
- R2: When `dev_type` times `interleave` exceeds `bus_bytes` and `cmd_ofs[7:0]` is 0xAA, `bus_addr` is the R1 product ORed with (`dev_type` shifted right by one) times `interleave`.
- R3: The lane width is `bus_bytes`/`interleave`. A geometry is legal only when `bus_bytes` and `interleave` are each 1, 2, 4 or 8, `interleave` does not exceed `bus_bytes`, and the lane width is 1, 2 or 4. Otherwise `geom_err` is 1 and `bus_addr`, `bus_data` and `status_out` are all zero.
- R4: With `big_endian` = 0, byte 0 of every lane (bits [7:0] counted from the lane's low end) carries `cmd`, and every other byte of the lane is zero.
- R5: With `big_endian` = 1, the top byte of every lane carries `cmd`, and the other bytes of the lane are zero.
- R6: The lane pattern repeats in every lane of a native word (native word width = `NATIVE_BYTES`, default 4 bytes), so every lane within the bus width carries the same pattern.
- R7: When `bus_bytes` exceeds the native word width, each native word of the bus carries an identical copy. Bytes at or above `bus_bytes` are zero.
- R8: Status folding ORs together all native words of `status_in` that lie within `bus_bytes`. Bytes at or above `bus_bytes` are ignored. Lane 0 of the result is then ORed with lane 1 when there are 2 or more lanes per word, with lane 2 when there are 4 or more, and with lane 4 when there are 8.
- R9: `status_out` holds the folded lane 0, zero-extended to 32 bits. When `big_endian` = 1, its bytes are reversed within the lane width.
- R10: With `REG_OUT` = 1, an input strobe on `in_valid` loads all outputs at the next rising edge and raises `out_valid` for that cycle. Without a strobe, the outputs hold their values and `out_valid` is 0.
- R11: After reset, `out_valid`, `geom_err`, `bus_addr`, `bus_data` and `status_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| bus_bytes | input | 4 | Bus width in bytes |
| interleave | input | 4 | Number of devices side by side on the bus |
| dev_type | input | 3 | Device type width in bytes |
| big_endian | input | 1 | Lane byte order select |
| cmd | input | 8 | Command byte |
| cmd_ofs | input | OFS_W (16) | Command offset in device units |
| status_in | input | MAX_BUS_BYTES*8 (64) | Raw status word read from the bus |
| out_valid | output | 1 | Outputs updated this cycle |
| geom_err | output | 1 | Geometry not representable |
| bus_addr | output | OFS_W+5 (21) | Bus byte address |
| bus_data | output | MAX_BUS_BYTES*8 (64) | Replicated command word |
| status_out | output | 32 | Folded single-device status |

## Verification
The bench sweeps every bus width and interleave from 0 to 9 against all three device types, both byte orders and a plain offset versus a 0xAA offset. This covers every illegal split, such as an interleave wider than the bus or an 8-byte lane, where a faulty design would leak a command pattern or a stale address instead of zeros. Offsets ending in 0xAA on narrow buses catch an unlock adjustment that is skipped, applied on wide buses where it does not belong, or ORed with the wrong weight. Eight-byte buses exercise the two-word copy and a fold that must ignore status bytes beyond the bus width or skip a lane. Big-endian lanes of two and four bytes show a byte swap that is missing or applied at the wrong width. Hold checks between strobes catch a register that reloads without a strobe.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

   typedef struct packed {
      logic       legal;
      logic [3:0] chip_mode;   // lane width in bytes
      logic [3:0] cpw;         // lanes per native word
      logic [3:0] wpb;         // native words per bus
      logic [3:0] word_bytes;  // bytes used in each native word
   } geom_t;

   function automatic logic is_pow2(input logic [7:0] v);
      return (v != 8'd0) && ((v & (v - 8'd1)) == 8'd0);
   endfunction

endpackage

// File: rtl/flash_geom_decode.sv
module flash_geom_decode
   import flash_enc_pkg::*;
#(
   parameter int NATIVE_BYTES  = 4,
   parameter int MAX_BUS_BYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  bus_bytes,
   input  logic [3:0]  interleave,
   output geom_t       geom
);
   localparam logic [7:0] NB8  = 8'(NATIVE_BYTES);
   localparam logic [7:0] MAX8 = 8'(MAX_BUS_BYTES);

   logic [7:0] bw8, il8, ww8, wpb8, cm8, cpw8;
   logic       mode_ok, cpw_ok, fit_ok;

   always_comb begin
      bw8  = {4'd0, bus_bytes};
      il8  = {4'd0, interleave};
      ww8  = (bw8 > NB8) ? NB8 : bw8;
      wpb8 = (ww8 != 8'd0) ? (bw8 / ww8) : 8'd0;
      cm8  = (il8 != 8'd0) ? (bw8 / il8) : 8'd0;
      cpw8 = (bw8 != 8'd0) ? ((ww8 * il8) / bw8) : 8'd0;
      mode_ok = (cm8 == 8'd1) || (cm8 == 8'd2) || (cm8 == 8'd4);
      cpw_ok  = is_pow2(cpw8) && (cpw8 <= 8'd8);
      fit_ok  = ((cm8 * cpw8) == ww8) && ((wpb8 * ww8) == bw8);
      geom.legal      = is_pow2(bw8) && is_pow2(il8) && (bw8 <= MAX8) &&
                        (il8 <= bw8) && mode_ok && cpw_ok && fit_ok;
      geom.chip_mode  = cm8[3:0];
      geom.cpw        = cpw8[3:0];
      geom.wpb        = wpb8[3:0];
      geom.word_bytes = ww8[3:0];
   end

   // a legal split always rebuilds the bus width from lanes and devices
   AST_MODE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      geom.legal |-> (({4'd0, geom.chip_mode} * il8) == bw8)); // R3

endmodule

// File: rtl/flash_cmd_addr.sv
module flash_cmd_addr #(
   parameter int OFS_W  = 16,
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_bytes,
   input  logic [3:0]        interleave,
   input  logic [2:0]        dev_type,
   input  logic [OFS_W-1:0]  cmd_ofs,
   output logic [ADDR_W-1:0] addr
);
   logic [7:0]        scale, tweak;
   logic [ADDR_W-1:0] base;
   logic              compat;

   always_comb begin
      scale  = {5'd0, dev_type} * {4'd0, interleave};
      tweak  = {5'd0, (dev_type >> 1)} * {4'd0, interleave};
      base   = ADDR_W'(cmd_ofs) * ADDR_W'(scale);
      compat = (scale > {4'd0, bus_bytes}) && (cmd_ofs[7:0] == 8'hAA);
      addr   = compat ? (base | ADDR_W'(tweak)) : base;
   end

   AST_ADDR_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
      (!compat && scale != 8'd0) |-> ((addr % ADDR_W'(scale)) == '0)); // R1
   AST_UNLOCK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      compat |-> ((addr & ADDR_W'(tweak)) == ADDR_W'(tweak))); // R2

endmodule

// File: rtl/flash_cmd_replicate.sv
module flash_cmd_replicate
   import flash_enc_pkg::*;
#(
   parameter int NATIVE_BYTES  = 4,
   parameter int MAX_BUS_BYTES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  geom_t                      geom,
   input  logic                       big_endian,
   input  logic [7:0]                 cmd,
   output logic [MAX_BUS_BYTES*8-1:0] data
);
   localparam int NW        = NATIVE_BYTES * 8;
   localparam int MAX_WORDS = MAX_BUS_BYTES / NATIVE_BYTES;

   logic [7:0]    sh8, sh16, sh32;
   logic [NW-1:0] one_cmd, rep8, rep4, rep2;

   always_comb begin
      sh8  = {1'b0, geom.chip_mode, 3'b000};
      sh16 = {geom.chip_mode, 4'b0000};
      sh32 = sh16 << 1;
      one_cmd = big_endian ? (NW'(cmd) << (sh8 - 8'd8)) : NW'(cmd);
   end

   generate
      if (NATIVE_BYTES >= 8) begin : g_step32
         assign rep8 = (geom.cpw == 4'd8) ? (one_cmd | (one_cmd << sh32)) : one_cmd;
      end else begin : g_no_step32
         assign rep8 = one_cmd;
      end
   endgenerate

   assign rep4 = (geom.cpw >= 4'd4) ? (rep8 | (rep8 << sh16)) : rep8;
   assign rep2 = (geom.cpw >= 4'd2) ? (rep4 | (rep4 << sh8)) : rep4;

   generate
      for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
         assign data[w*NW +: NW] = (geom.legal && (4'(w) < geom.wpb)) ? rep2 : '0;
      end
   endgenerate

   AST_CMD_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (geom.legal && !big_endian) |-> (data[7:0] == cmd)); // R4
   AST_CMD_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (geom.legal && big_endian) |-> (data[(sh8 - 8'd8) +: 8] == cmd)); // R5
   AST_LANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (geom.legal && geom.cpw >= 4'd2) |-> (data[sh8 +: 8] == data[7:0])); // R6

   generate
      if (MAX_WORDS > 1) begin : g_word_chk
         AST_WORD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (geom.legal && geom.wpb >= 4'd2) |-> (data[2*NW-1:NW] == data[NW-1:0])); // R7
      end
   endgenerate

endmodule

// File: rtl/flash_status_fold.sv
module flash_status_fold
   import flash_enc_pkg::*;
#(
   parameter int NATIVE_BYTES  = 4,
   parameter int MAX_BUS_BYTES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  geom_t                      geom,
   input  logic                       big_endian,
   input  logic [MAX_BUS_BYTES*8-1:0] status_in,
   output logic [31:0]                status_out
);
   localparam int NW        = NATIVE_BYTES * 8;
   localparam int MAX_WORDS = MAX_BUS_BYTES / NATIVE_BYTES;

   logic [7:0]    sh8, sh16, sh32;
   logic [NW-1:0] words_or, folded;
   logic [31:0]   lane;

   always_comb begin
      sh8  = {1'b0, geom.chip_mode, 3'b000};
      sh16 = {geom.chip_mode, 4'b0000};
      sh32 = sh16 << 1;
      words_or = '0;
      for (int w = 0; w < MAX_WORDS; w++) begin
         if (4'(w) < geom.wpb) words_or = words_or | status_in[w*NW +: NW];
      end
      for (int b = 0; b < NATIVE_BYTES; b++) begin
         if (4'(b) >= geom.word_bytes) words_or[b*8 +: 8] = 8'd0;
      end
      folded = words_or;
      if (NATIVE_BYTES >= 8 && geom.cpw == 4'd8) folded = folded | (words_or >> sh32);
      if (geom.cpw >= 4'd4) folded = folded | (words_or >> sh16);
      if (geom.cpw >= 4'd2) folded = folded | (words_or >> sh8);
      lane = folded[31:0];
      case (geom.chip_mode)
         4'd1:    status_out = {24'd0, lane[7:0]};
         4'd2:    status_out = big_endian ? {16'd0, lane[7:0], lane[15:8]}
                                          : {16'd0, lane[15:0]};
         4'd4:    status_out = big_endian ? {lane[7:0], lane[15:8], lane[23:16], lane[31:24]}
                                          : lane;
         default: status_out = 32'd0;
      endcase
      if (!geom.legal) status_out = 32'd0;
   end

   AST_FOLD_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (geom.legal && !big_endian && geom.chip_mode == 4'd1 && geom.wpb == 4'd1)
      |-> ((status_out[7:0] & status_in[7:0]) == status_in[7:0])); // R8
   AST_FOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !geom.legal |-> (status_out == 32'd0)); // R3
   AST_FOLD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (geom.legal && geom.chip_mode == 4'd2) |-> (status_out[31:16] == 16'd0)); // R9

endmodule

// File: rtl/flash_cmd_encoder.sv
module flash_cmd_encoder
   import flash_enc_pkg::*;
#(
   parameter int NATIVE_BYTES  = 4,
   parameter int MAX_BUS_BYTES = 8,
   parameter int OFS_W         = 16,
   parameter bit REG_OUT       = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [3:0]                   bus_bytes,
   input  logic [3:0]                   interleave,
   input  logic [2:0]                   dev_type,
   input  logic                         big_endian,
   input  logic [7:0]                   cmd,
   input  logic [OFS_W-1:0]             cmd_ofs,
   input  logic [MAX_BUS_BYTES*8-1:0]   status_in,
   output logic                         out_valid,
   output logic                         geom_err,
   output logic [OFS_W+4:0]             bus_addr,
   output logic [MAX_BUS_BYTES*8-1:0]   bus_data,
   output logic [31:0]                  status_out
);
   localparam int ADDR_W = OFS_W + 5;
   localparam int DW     = MAX_BUS_BYTES * 8;

   initial begin
      assert ((NATIVE_BYTES == 4) || (NATIVE_BYTES == 8))
         else $fatal(1, "NATIVE_BYTES must be 4 or 8");
      assert ((MAX_BUS_BYTES >= NATIVE_BYTES) && (MAX_BUS_BYTES <= 8) &&
              ((MAX_BUS_BYTES % NATIVE_BYTES) == 0))
         else $fatal(1, "MAX_BUS_BYTES must be a multiple of NATIVE_BYTES up to 8");
      assert (OFS_W >= 8 && OFS_W <= 26)
         else $fatal(1, "OFS_W out of range");
   end

   geom_t             geom;
   logic [ADDR_W-1:0] addr_raw, addr_c;
   logic [DW-1:0]     data_c;
   logic [31:0]       status_c;
   logic              err_c;

   flash_geom_decode #(
      .NATIVE_BYTES (NATIVE_BYTES),
      .MAX_BUS_BYTES(MAX_BUS_BYTES)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_bytes (bus_bytes),
      .interleave(interleave),
      .geom      (geom)
   );

   flash_cmd_addr #(
      .OFS_W (OFS_W),
      .ADDR_W(ADDR_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_bytes (bus_bytes),
      .interleave(interleave),
      .dev_type  (dev_type),
      .cmd_ofs   (cmd_ofs),
      .addr      (addr_raw)
   );

   flash_cmd_replicate #(
      .NATIVE_BYTES (NATIVE_BYTES),
      .MAX_BUS_BYTES(MAX_BUS_BYTES)
   ) u_rep (
      .clk       (clk),
      .rst_n     (rst_n),
      .geom      (geom),
      .big_endian(big_endian),
      .cmd       (cmd),
      .data      (data_c)
   );

   flash_status_fold #(
      .NATIVE_BYTES (NATIVE_BYTES),
      .MAX_BUS_BYTES(MAX_BUS_BYTES)
   ) u_fold (
      .clk       (clk),
      .rst_n     (rst_n),
      .geom      (geom),
      .big_endian(big_endian),
      .status_in (status_in),
      .status_out(status_c)
   );

   assign err_c  = !geom.legal;
   assign addr_c = err_c ? '0 : addr_raw;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               geom_err   <= 1'b0;
               bus_addr   <= '0;
               bus_data   <= '0;
               status_out <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  geom_err   <= err_c;
                  bus_addr   <= addr_c;
                  bus_data   <= data_c;
                  status_out <= status_c;
               end
            end
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && in_valid) |=> out_valid); // R10
         AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(bus_data) && $stable(bus_addr))); // R10
      end else begin : g_comb
         assign out_valid  = in_valid;
         assign geom_err   = err_c;
         assign bus_addr   = addr_c;
         assign bus_data   = data_c;
         assign status_out = status_c;
      end
   endgenerate

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      geom_err |-> (bus_data == '0 && bus_addr == '0 && status_out == 32'd0)); // R3

endmodule

// File: tb/tb_flash_cmd_encoder.sv
module tb_flash_cmd_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  bus_bytes = 4'd0;
   logic [3:0]  interleave = 4'd0;
   logic [2:0]  dev_type = 3'd0;
   logic        big_endian = 1'b0;
   logic [7:0]  cmd = 8'd0;
   logic [15:0] cmd_ofs = 16'd0;
   logic [63:0] status_in = 64'd0;
   logic        out_valid, geom_err;
   logic [20:0] bus_addr;
   logic [63:0] bus_data;
   logic [31:0] status_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #10 clk = ~clk;

   flash_cmd_encoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_bytes(bus_bytes),
      .interleave(interleave), .dev_type(dev_type), .big_endian(big_endian),
      .cmd(cmd), .cmd_ofs(cmd_ofs), .status_in(status_in), .out_valid(out_valid),
      .geom_err(geom_err), .bus_addr(bus_addr), .bus_data(bus_data),
      .status_out(status_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit pw2(input int v);
      return (v == 1) || (v == 2) || (v == 4) || (v == 8);
   endfunction

   function automatic bit legal_g(input int bw, input int il);
      return pw2(bw) && pw2(il) && (il <= bw) && ((bw / il) <= 4);
   endfunction

   function automatic logic [63:0] exp_data(input int bw, input int il, input bit be,
                                            input logic [7:0] c);
      logic [63:0] r = 64'd0;
      int cm;
      if (!legal_g(bw, il)) return 64'd0;
      cm = bw / il;
      for (int j = 0; j < bw; j++)
         if ((j % cm) == (be ? cm - 1 : 0)) r[j*8 +: 8] = c;
      return r;
   endfunction

   function automatic logic [31:0] exp_stat(input int bw, input int il, input bit be,
                                            input logic [63:0] st);
      logic [7:0] on [4];
      logic [7:0] v [4];
      logic [31:0] r = 32'd0;
      int ww, wpb, cm, cpw;
      if (!legal_g(bw, il)) return 32'd0;
      ww = (bw > 4) ? 4 : bw;
      wpb = bw / ww;
      cm = bw / il;
      cpw = ww / cm;
      for (int b = 0; b < 4; b++) begin
         on[b] = 8'd0;
         if (b < ww)
            for (int w = 0; w < wpb; w++) on[b] = on[b] | st[(w*ww + b)*8 +: 8];
      end
      for (int i = 0; i < 4; i++) begin
         v[i] = 8'd0;
         if (i < cm) begin
            v[i] = on[i];
            if (cpw >= 2 && cm + i < 4) v[i] = v[i] | on[cm + i];
            if (cpw >= 4 && 2*cm + i < 4) v[i] = v[i] | on[2*cm + i];
            if (cpw >= 8 && 4*cm + i < 4) v[i] = v[i] | on[4*cm + i];
         end
      end
      for (int i = 0; i < cm; i++) r[i*8 +: 8] = be ? v[cm-1-i] : v[i];
      return r;
   endfunction

   function automatic logic [63:0] next_rng(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   task automatic apply(input int bw, input int il, input int ty, input bit be,
                        input logic [7:0] c, input logic [15:0] ofs);
      logic [63:0] ed;
      logic [31:0] es;
      int ea;
      bit lg, compat;
      string rq;
      @(negedge clk);
      rng = next_rng(rng);
      bus_bytes = 4'(bw); interleave = 4'(il); dev_type = 3'(ty);
      big_endian = be; cmd = c; cmd_ofs = ofs; status_in = rng; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lg = legal_g(bw, il);
      compat = (ty * il > bw) && (ofs[7:0] == 8'hAA);
      ea = int'(ofs) * ty * il;
      if (compat) ea = ea | ((ty >> 1) * il);
      if (!lg) ea = 0;
      ed = exp_data(bw, il, be, c);
      es = exp_stat(bw, il, be, rng);
      check(out_valid == 1'b1, "R10", "valid after strobe", 64'(out_valid), 64'd1);
      check(geom_err == !lg, "R3", "geometry error", 64'(geom_err), 64'(!lg));
      check(bus_addr == 21'(ea), compat ? "R2" : "R1", "address",
            64'(bus_addr), 64'(21'(ea)));
      rq = !lg ? "R3" : (be ? "R5" : "R4");
      check(bus_data[31:0] == ed[31:0], rq, "low word data (R6 lanes)",
            64'(bus_data[31:0]), 64'(ed[31:0]));
      check(bus_data[63:32] == ed[63:32], lg ? "R7" : "R3", "high word data",
            64'(bus_data[63:32]), 64'(ed[63:32]));
      check(status_out == es, !lg ? "R3" : (be ? "R9" : "R8"), "folded status",
            64'(status_out), 64'(es));
   endtask

   task automatic hold_check();
      logic [63:0] d0 = bus_data;
      logic [20:0] a0 = bus_addr;
      @(negedge clk);
      cmd = ~cmd; cmd_ofs = cmd_ofs + 16'd3; status_in = ~status_in;
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "no valid without strobe", 64'(out_valid), 64'd0);
      check(bus_data == d0 && bus_addr == a0, "R10", "outputs hold",
            bus_data, d0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(out_valid == 1'b0 && geom_err == 1'b0, "R11", "flags in reset",
            64'({out_valid, geom_err}), 64'd0);
      check(bus_data == 64'd0 && bus_addr == 21'd0 && status_out == 32'd0, "R11",
            "outputs in reset", bus_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && bus_data == 64'd0, "R11", "after release",
            bus_data, 64'd0);
      for (int bw = 0; bw < 10; bw++)
         for (int il = 0; il < 10; il++)
            for (int ti = 0; ti < 3; ti++)
               for (int be = 0; be < 2; be++)
                  for (int p = 0; p < 2; p++) begin
                     logic [7:0] c = (p == 0) ? 8'h98 : 8'(8'hA5 ^ (bw*16 + il));
                     logic [15:0] o = (p == 0) ? 16'(16'h0055 + bw) : 16'h2AAA;
                     apply(bw, il, 1 << ti, be[0], c, o);
                     if (p == 1 && ti == 2 && be == 1) hold_check();
                  end
      // unlock offsets beyond the low byte
      apply(1, 1, 2, 1'b0, 8'h55, 16'h55AA);
      apply(2, 2, 2, 1'b1, 8'hF0, 16'hFFAA);
      apply(8, 8, 4, 1'b0, 8'h90, 16'h00AA);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule